// File: doc/BRIEF.md
# Memory Retention Pattern Tester

This block measures how long a dynamic memory keeps its contents once refresh stops. It drives the refresh-enable input of an existing memory controller. It talks to that controller through a simple word port: a request is held until an acknowledge returns.

When a run is started, the tester turns refresh off. It then fills every location with a balanced pattern: the chosen word at even addresses and its bitwise complement at odd addresses. Next it walks the same address sequence again, reading one word at a time. Before each read it waits a programmable number of idle cycles, so the sweep can last far longer than the nominal retention time. Each word read back is compared with the value that was written. Every difference is reported as an error record carrying:
- the address,
- the word read,
- the word expected,
- a timestamp from a free-running cycle counter.

Runs may be repeated with a different start address, and the address sequence wraps modulo the memory depth. Runs may also use a different pattern, picked from a small set of programmable words. The length of the read-back sweep is reported in cycles so that it can be compared with the retention target.

Top module: `ret_tester`

## Requirements
- R1: After reset `refresh_en_o` is 1, and `busy_o`, `done_o`, `mem_req_o`, `err_valid_o` and `err_count_o` are all 0.
- R2: `refresh_en_o` is 0 from the cycle after a start is accepted until the run ends. It is 1 again once the tester is idle after completion or abort. No memory request is made while it is 1.
- R3: The fill phase issues exactly 2^AW write requests, with `mem_we_o`=1. The first address is the start address and each next address is the previous plus one modulo 2^AW. The data is the selected pattern at even addresses and its bitwise complement at odd addresses. Each request holds its address and data until `mem_ack_i`.
- R4: The pattern is the word at bits [k*DW +: DW] of `pat_set_i`, where k is the value of `pat_sel_i` sampled together with the accepted start.
- R5: The read-back phase begins only after the last fill acknowledge and reads the same 2^AW addresses in the same order. Each read request is preceded by at least interval+1 cycles with no request, where interval is `interval_i` sampled at start.
- R6: A read word that differs from the expected word raises `err_valid_o` with the address, the read word, the expected word and the timestamp taken in the cycle of the read acknowledge. The record holds stable until `err_ready_i` is 1. The timestamp advances by one per clock cycle.
- R7: A read word equal to the expected word produces no error record.
- R8: `err_count_o` counts accepted error records, saturates at its all-ones value, and clears when a start is accepted.
- R9: `done_o` becomes 1 when a run completes and stays 1 until the next accepted start. A start while `busy_o` is 1 is ignored.
- R10: `sweep_cycles_o` counts the cycles spent in the read-back phase. With a one-cycle acknowledge and no stalled records, this is 2^AW*(interval+3).
- R11: `abort_i` during a run ends it after any outstanding request is acknowledged. The tester then returns to idle with `refresh_en_o`=1 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| abort_i | input | 1 | Abort request during a run |
| start_addr_i | input | AW | First address of the sweep |
| pat_sel_i | input | PSW | Index into the pattern set |
| pat_set_i | input | NP*DW | Packed programmable patterns |
| interval_i | input | IW | Idle cycles before each read, minus one |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Request address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Request acknowledge, with read data |
| mem_rdata_i | input | DW | Read data |
| refresh_en_o | output | 1 | Refresh enable toward the controller |
| err_valid_o | output | 1 | Error record valid |
| err_ready_i | input | 1 | Error record ready |
| err_addr_o | output | AW | Failing address |
| err_rdata_o | output | DW | Word read |
| err_exp_o | output | DW | Word expected |
| err_time_o | output | TW | Timestamp at read acknowledge |
| err_count_o | output | CW | Saturating error count |
| sweep_cycles_o | output | SW | Read-back phase length in cycles |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |

## Verification
Most faults in the address sequencer show up at the first wrong write request. A skipped or repeated address is visible within two cycles of the fill acknowledge that follows it. A wrong complement rule is visible on the first odd address. The interval counter and the phase boundary can only be seen through timing, so the bench checks two things for exact values: the spacing between timestamps of adjacent failing addresses, and the final sweep length. Saturation and the handshake on error records are stressed with every location corrupted and with `err_ready_i` toggling, so a lost or duplicated record leaves the scoreboard queue unbalanced at the end of the run.

// File: rtl/ret_pkg.sv
package ret_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_WAIT, ST_READ, ST_CMP, ST_DONE
  } state_e;
endpackage

// File: rtl/ret_ticker.sv
module ret_ticker #(
  parameter int TW = 32,
  parameter int IW = 8,
  parameter int SW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ivl_clr_i,
  input  logic [IW-1:0] ivl_limit_i,
  input  logic          sweep_clr_i,
  input  logic          sweep_run_i,
  output logic [TW-1:0] ts_o,
  output logic          ivl_hit_o,
  output logic [SW-1:0] sweep_o
);
  logic [IW-1:0] ivl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ivl_cnt <= '0;
    else if (ivl_clr_i) ivl_cnt <= '0;
    else                ivl_cnt <= ivl_cnt + 1'b1;
  end

  assign ivl_hit_o = (ivl_cnt == ivl_limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         sweep_o <= '0;
    else if (sweep_clr_i)                sweep_o <= '0;
    else if (sweep_run_i && !(&sweep_o)) sweep_o <= sweep_o + 1'b1;
  end

  AST_IVL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ivl_clr_i |-> ivl_cnt <= ivl_limit_i); // R5
endmodule

// File: rtl/ret_err_cnt.sv
module ret_err_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (inc_i && !(&cnt_o))  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) && !clr_i |=> (&cnt_o)); // R8
endmodule

// File: rtl/ret_fsm.sv
module ret_fsm
  import ret_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int IW = 8,
  parameter int TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] pat_i,
  input  logic [IW-1:0] interval_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [TW-1:0] ts_i,
  input  logic          ivl_hit_i,
  input  logic          err_ready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          refresh_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          start_acc_o,
  output logic          ivl_clr_o,
  output logic [IW-1:0] ivl_limit_o,
  output logic          sweep_run_o,
  output logic          err_valid_o,
  output logic [AW-1:0] err_addr_o,
  output logic [DW-1:0] err_rdata_o,
  output logic [DW-1:0] err_exp_o,
  output logic [TW-1:0] err_time_o
);
  state_e        state_q;
  logic [AW-1:0] addr_q, step_q, start_q;
  logic [DW-1:0] pat_q, rd_data_q, exp_w;
  logic [IW-1:0] ivl_q;
  logic [TW-1:0] rd_time_q;
  logic          abort_q, done_q, last_w, mismatch_w;

  // even address: pattern, odd address: complement
  assign exp_w       = addr_q[0] ? ~pat_q : pat_q;
  assign last_w      = &step_q;
  assign mismatch_w  = (rd_data_q != exp_w);
  assign start_acc_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      step_q    <= '0;
      start_q   <= '0;
      pat_q     <= '0;
      ivl_q     <= '0;
      rd_data_q <= '0;
      rd_time_q <= '0;
      abort_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (abort_i && state_q != ST_IDLE) abort_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          abort_q <= 1'b0;
          if (start_i) begin
            addr_q  <= start_addr_i;
            start_q <= start_addr_i;
            pat_q   <= pat_i;
            ivl_q   <= interval_i;
            step_q  <= '0;
            done_q  <= 1'b0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: if (mem_ack_i) begin
          if (abort_q) state_q <= ST_IDLE;
          else if (last_w) begin
            addr_q  <= start_q;
            step_q  <= '0;
            state_q <= ST_WAIT;
          end else begin
            addr_q <= addr_q + 1'b1;
            step_q <= step_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (abort_q)        state_q <= ST_IDLE;
          else if (ivl_hit_i) state_q <= ST_READ;
        end
        ST_READ: if (mem_ack_i) begin
          rd_data_q <= mem_rdata_i;
          rd_time_q <= ts_i;
          state_q   <= ST_CMP;
        end
        ST_CMP: if (!mismatch_w || err_ready_i) begin
          if (last_w) state_q <= ST_DONE;
          else begin
            addr_q  <= addr_q + 1'b1;
            step_q  <= step_q + 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == ST_FILL) || (state_q == ST_READ);
  assign mem_we_o     = (state_q == ST_FILL);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = exp_w;
  assign refresh_en_o = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign ivl_clr_o    = (state_q != ST_WAIT);
  assign ivl_limit_o  = ivl_q;
  assign sweep_run_o  = (state_q == ST_WAIT) || (state_q == ST_READ) || (state_q == ST_CMP);
  assign err_valid_o  = (state_q == ST_CMP) && mismatch_w;
  assign err_addr_o   = addr_q;
  assign err_rdata_o  = rd_data_q;
  assign err_exp_o    = exp_w;
  assign err_time_o   = rd_time_q;

  AST_NO_REFRESH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !refresh_en_o); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R3
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o && !err_ready_i |=> err_valid_o && $stable(err_addr_o) && $stable(err_time_o)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
endmodule

// File: rtl/ret_tester.sv
module ret_tester #(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int NP  = 4,
  parameter int IW  = 8,
  parameter int TW  = 32,
  parameter int CW  = 4,
  parameter int SW  = 24,
  localparam int PSW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [PSW-1:0]   pat_sel_i,
  input  logic [NP*DW-1:0] pat_set_i,
  input  logic [IW-1:0]    interval_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             refresh_en_o,
  output logic             err_valid_o,
  input  logic             err_ready_i,
  output logic [AW-1:0]    err_addr_o,
  output logic [DW-1:0]    err_rdata_o,
  output logic [DW-1:0]    err_exp_o,
  output logic [TW-1:0]    err_time_o,
  output logic [CW-1:0]    err_count_o,
  output logic [SW-1:0]    sweep_cycles_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [DW-1:0] pat_arr [NP];
  logic [DW-1:0] pat_cur;
  logic [TW-1:0] ts;
  logic [IW-1:0] ivl_limit;
  logic          ivl_hit, ivl_clr, sweep_run, start_acc;

  for (genvar k = 0; k < NP; k++) begin : g_pat
    assign pat_arr[k] = pat_set_i[k*DW +: DW];
  end
  assign pat_cur = pat_arr[pat_sel_i];

  ret_ticker #(.TW(TW), .IW(IW), .SW(SW)) u_ticker (
    .clk_i, .rst_ni,
    .ivl_clr_i   (ivl_clr),
    .ivl_limit_i (ivl_limit),
    .sweep_clr_i (start_acc),
    .sweep_run_i (sweep_run),
    .ts_o        (ts),
    .ivl_hit_o   (ivl_hit),
    .sweep_o     (sweep_cycles_o)
  );

  ret_err_cnt #(.CW(CW)) u_err_cnt (
    .clk_i, .rst_ni,
    .clr_i (start_acc),
    .inc_i (err_valid_o && err_ready_i),
    .cnt_o (err_count_o)
  );

  ret_fsm #(.AW(AW), .DW(DW), .IW(IW), .TW(TW)) u_fsm (
    .clk_i, .rst_ni,
    .start_i, .abort_i, .start_addr_i,
    .pat_i        (pat_cur),
    .interval_i,
    .mem_ack_i, .mem_rdata_i,
    .ts_i         (ts),
    .ivl_hit_i    (ivl_hit),
    .err_ready_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .refresh_en_o, .busy_o, .done_o,
    .start_acc_o  (start_acc),
    .ivl_clr_o    (ivl_clr),
    .ivl_limit_o  (ivl_limit),
    .sweep_run_o  (sweep_run),
    .err_valid_o, .err_addr_o, .err_rdata_o, .err_exp_o, .err_time_o
  );
endmodule

// File: tb/tb_ret_tester.sv
module tb_ret_tester;
  localparam int AW = 4, DW = 8, NP = 4, IW = 8, TW = 32, CW = 4, SW = 24;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] r;
    logic [DW-1:0] e;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, abort = 0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] pat_sel = '0;
  logic [NP*DW-1:0] pat_set = {8'h5A, 8'h33, 8'h0F, 8'hAA};
  logic [IW-1:0] interval = '0;
  logic mem_req, mem_we, mem_ack = 0, refresh_en, err_valid, err_ready = 1;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0, err_rdata, err_exp;
  logic [TW-1:0] err_time;
  logic [CW-1:0] err_count;
  logic [SW-1:0] sweep;
  logic busy, done;

  always #2.5 clk = ~clk;

  ret_tester #(.AW(AW), .DW(DW), .NP(NP), .IW(IW), .TW(TW), .CW(CW), .SW(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .start_addr_i(start_addr), .pat_sel_i(pat_sel), .pat_set_i(pat_set),
    .interval_i(interval), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .refresh_en_o(refresh_en), .err_valid_o(err_valid),
    .err_ready_i(err_ready), .err_addr_o(err_addr), .err_rdata_o(err_rdata),
    .err_exp_o(err_exp), .err_time_o(err_time), .err_count_o(err_count),
    .sweep_cycles_o(sweep), .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  item_t sb_q[$];
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] flip [DEPTH];
  logic [AW-1:0] exp_start;
  logic [DW-1:0] exp_pat;
  int wr_n = 0, rd_n = 0, cur_ivl = 0, gap = 0;
  bit bp_mode = 0, have_prev = 0;
  logic [AW-1:0] prev_a;
  logic [TW-1:0] prev_t;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a, input logic [DW-1:0] p);
    return a[0] ? ~p : p;
  endfunction

  // memory model: one-cycle acknowledge, corruption applied on read
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      chk(refresh_en == 0, "R2", "refresh during request", refresh_en, 0);
      if (mem_we) begin
        logic [AW-1:0] ea;
        ea = exp_start + AW'(wr_n);
        chk(mem_addr == ea, "R3", "write addr", mem_addr, ea);
        chk(mem_wdata == exp_word(ea, exp_pat), "R3/R4", "write data", mem_wdata, exp_word(ea, exp_pat));
        mem[mem_addr] = mem_wdata;
        wr_n++;
      end else begin
        logic [AW-1:0] ea;
        ea = exp_start + AW'(rd_n);
        chk(wr_n == DEPTH, "R5", "read before fill end", wr_n, DEPTH);
        chk(mem_addr == ea, "R5", "read addr", mem_addr, ea);
        chk(gap >= cur_ivl + 1, "R5", "idle gap", gap, cur_ivl + 1);
        mem_rdata = mem[mem_addr] ^ flip[mem_addr];
        rd_n++;
      end
      mem_ack = 1;
    end
    gap = mem_req ? 0 : gap + 1;
  end

  // scoreboard monitor; ready for the coming edge is decided before sampling
  always @(negedge clk) begin
    err_ready = bp_mode ? ~err_ready : 1'b1;
    if (rst_n && err_valid && err_ready) begin
      if (sb_q.size() == 0) chk(0, "R7", "unexpected record addr", err_addr, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(err_addr == it.a, "R6", "record addr", err_addr, it.a);
        chk(err_rdata == it.r, "R6", "record rdata", err_rdata, it.r);
        chk(err_exp == it.e, "R6", "record expected", err_exp, it.e);
      end
      if (!bp_mode && have_prev && err_addr == prev_a + 1'b1)
        chk(err_time - prev_t == TW'(cur_ivl + 3), "R6", "timestamp spacing",
            err_time - prev_t, cur_ivl + 3);
      have_prev = 1; prev_a = err_addr; prev_t = err_time;
    end
  end

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy && n < lim) begin @(negedge clk); n++; end
    chk(!busy, "R9", "run did not end", busy, 0);
  endtask

  task automatic run(input logic [AW-1:0] st, input logic [1:0] sel, input int ivl,
                     input bit bp, input bit poke);
    exp_start = st; exp_pat = pat_set[sel*DW +: DW];
    wr_n = 0; rd_n = 0; cur_ivl = ivl; bp_mode = bp; have_prev = 0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [AW-1:0] a;
      a = st + AW'(i);
      if (flip[a] != 0) sb_q.push_back({a, exp_word(a, exp_pat) ^ flip[a], exp_word(a, exp_pat)});
    end
    @(negedge clk);
    start = 1; start_addr = st; pat_sel = sel; interval = IW'(ivl);
    @(negedge clk);
    start = 0;
    chk(busy && !refresh_en, "R2", "refresh off at run start", refresh_en, 0);
    chk(err_count == 0 && !done, "R8", "count cleared at start", err_count, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1; start_addr = st + 4'd7; pat_sel = sel + 2'd1;
      @(negedge clk);
      start = 0;
    end
    wait_idle(20000);
    chk(done == 1, "R9", "done after run", done, 1);
    chk(refresh_en == 1, "R2", "refresh restored", refresh_en, 1);
    chk(wr_n == DEPTH && rd_n == DEPTH, "R5", "op count", wr_n + rd_n, 2 * DEPTH);
    chk(sb_q.size() == 0, "R6", "records missing", sb_q.size(), 0);
    sb_q.delete();
    bp_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; flip[i] = '0; end
    repeat (3) @(negedge clk);
    chk(refresh_en && !busy && !done && !mem_req && !err_valid && err_count == 0,
        "R1", "reset state", {refresh_en, busy, done, mem_req, err_valid}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // clean run: no records, exact sweep length
    run(4'd0, 2'd0, 2, 0, 0);
    chk(err_count == 0, "R7", "no errors on clean run", err_count, 0);
    chk(sweep == SW'(DEPTH * (2 + 3)), "R10", "sweep cycles ivl2", sweep, DEPTH * 5);

    // wrapped start, other pattern, adjacent failures, start ignored mid-run
    flip[14] = 8'h01; flip[15] = 8'h80; flip[0] = 8'h10;
    run(4'd13, 2'd2, 5, 0, 1);
    chk(err_count == 3, "R8", "count three", err_count, 3);
    chk(sweep == SW'(DEPTH * (5 + 3)), "R10", "sweep cycles ivl5", sweep, DEPTH * 8);

    // backpressure on records
    for (int i = 0; i < DEPTH; i++) flip[i] = '0;
    flip[3] = 8'hFF; flip[4] = 8'h02; flip[9] = 8'h40; flip[10] = 8'h11;
    run(4'd2, 2'd1, 0, 1, 0);
    chk(err_count == 4, "R8", "count four with stalls", err_count, 4);

    // every word corrupted: counter saturates
    for (int i = 0; i < DEPTH; i++) flip[i] = 8'h04;
    run(4'd5, 2'd3, 0, 0, 0);
    chk(err_count == {CW{1'b1}}, "R8", "saturation", err_count, {CW{1'b1}});

    // abort during fill
    for (int i = 0; i < DEPTH; i++) flip[i] = '0;
    exp_start = 4'd0; exp_pat = pat_set[0 +: DW]; wr_n = 0; rd_n = 0;
    @(negedge clk);
    start = 1; start_addr = 4'd0; pat_sel = 2'd0; interval = 8'd3;
    @(negedge clk);
    start = 0;
    chk(err_count == 0, "R8", "cleared by start", err_count, 0);
    repeat (7) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    wait_idle(20);
    chk(done == 0, "R11", "done after abort", done, 0);
    chk(refresh_en == 1, "R11", "refresh after abort", refresh_en, 1);
    chk(wr_n < DEPTH && rd_n == 0, "R11", "run cut short", wr_n, DEPTH - 1);

    // tester still usable after abort
    run(4'd9, 2'd0, 1, 0, 0);
    chk(err_count == 0, "R7", "clean after abort", err_count, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule